// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block drives the digital half of a 10-bit successive-approximation converter. It runs on its own free-running conversion clock. A start request comes from the serial port, which runs on an unrelated clock, so the request is passed through a synchronizer and its rising edge hands control to the sequencer. The sequencer then spends a fixed 44-cycle budget on the conversion. The first four cycles are a setup and sample phase. Each of the next ten four-cycle slots resolves one result bit, starting from the MSB. In each slot a trial bit is placed on the DAC code, and in the last cycle of the slot the comparator is sampled. The bit is kept when the held input is at or above the trial level.

During the setup phase the sequencer drives a one-hot sample-select output. This output connects either the external channel or an internal reference combination to the hold element. Channel addresses 0xB, 0xE and 0xF sample the reference midpoint, 0xC samples the lower reference and 0xD samples the upper reference. A healthy converter therefore returns 0x200, 0x000 and 0x3FF for these addresses. A chip-select recognized on the serial side may abort a conversion at any time. Completion gives a one-cycle done pulse and flips a level that the serial side can synchronize to raise its end-of-conversion flag.

Top module: `sar_conv_seq`

## Requirements
- R1: A rising edge on `start_req` is synchronized through two flops. `busy` goes high at the third rising conversion-clock edge after `start_req` rises, provided the sequencer is idle.
- R2: A conversion keeps `busy` high for exactly 44 clock cycles. In the cycle after the last one, `done` is high for exactly one cycle and `busy` is low.
- R3: For an external channel (addresses 0x0 to 0xA), `result` equals the largest code not above the held input. An input at or above full scale gives 0x3FF and an input of zero gives 0x000.
- R4: Address 0xB, 0xE or 0xF gives 0x200. Address 0xC gives 0x000. Address 0xD gives 0x3FF.
- R5: `smp_sel` is one-hot or zero. Bit 0 selects the external channel, bit 1 the midpoint, bit 2 the lower reference and bit 3 the upper reference. It is non-zero only in the first four busy cycles and is zero otherwise.
- R6: `abort_req` high while busy ends the conversion at the next edge. `busy` drops, `aborted` pulses for one cycle, `done` stays low and `result` keeps its previous value. This holds even on the 44th cycle.
- R7: A rising edge on `start_req` while busy is ignored. No second conversion follows.
- R8: `done_tgl` inverts on each completed conversion and does not change on abort.
- R9: Bits are tried MSB first. In busy cycles 4 to 7 `dac_code` is 0x200. In cycles 8 to 11 it is 0x100 plus the kept MSB.
- R10: After reset, `busy`, `done`, `aborted`, `done_tgl`, `result`, `dac_code` and `smp_sel` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running conversion clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Handoff request from serial domain (asynchronous level) |
| chan_addr | input | 4 | Latched channel address, stable around handoff |
| abort_req | input | 1 | Recognized chip select, synchronous to clk |
| cmp_hi | input | 1 | Comparator: held input at or above trial level |
| dac_code | output | 10 | Trial code for the DAC |
| smp_sel | output | 4 | One-hot sample source select |
| busy | output | 1 | Conversion in progress |
| result | output | 10 | Last completed conversion code |
| done | output | 1 | One-cycle completion pulse |
| aborted | output | 1 | One-cycle abort pulse |
| done_tgl | output | 1 | Toggles per completion, for crossing to serial domain |

## Verification
The bench goes after abort on the final budget cycle. A design that lets completion win there would overwrite `result` and flip `done_tgl`. It also raises `start_req` again in the middle of a conversion; a sequencer that re-arms would restart its count and stretch `busy` past 44 cycles. The three self-test addresses and the aliases 0xE and 0xF are each converted, because a wrong decode either samples the external pin or selects the wrong reference and misses 0x200, 0x000 or 0x3FF. Inputs at 0, at 1023 and above full scale check that the comparator polarity (at or above keeps the bit) and MSB-first ordering give the clipped codes instead of off-by-one values.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {SRC_EXT = 2'd0, SRC_MID = 2'd1, SRC_LO = 2'd2, SRC_HI = 2'd3} src_e;
  localparam int LAST_EXT_ADDR = 10;
  localparam int ADDR_LO_REF   = 12;
  localparam int ADDR_HI_REF   = 13;
endpackage

// File: rtl/sar_sync_edge.sv
module sar_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-1:0], async_in};
  end

  assign rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/sar_src_dec.sv
module sar_src_dec #(
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [3:0]        sel
);
  import sar_pkg::*;
  src_e src;

  always_comb begin
    if (int'(addr) <= LAST_EXT_ADDR)     src = SRC_EXT;
    else if (int'(addr) == ADDR_LO_REF)  src = SRC_LO;
    else if (int'(addr) == ADDR_HI_REF)  src = SRC_HI;
    else                                 src = SRC_MID;
  end

  always_comb begin
    sel = '0;
    sel[src] = 1'b1;
  end
endmodule

// File: rtl/sar_timer.sv
module sar_timer #(
  parameter int SETUP = 4,
  parameter int SLOT  = 4,
  parameter int NBITS = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic go,
  input  logic abort,
  output logic busy,
  output logic start,
  output logic setup_end,
  output logic decide,
  output logic last
);
  localparam int TOTAL = SETUP + SLOT * NBITS;
  localparam int CW    = $clog2(TOTAL + 1);
  localparam int PW    = (SLOT > 1) ? $clog2(SLOT) : 1;

  logic [CW-1:0] cnt;
  logic [PW-1:0] ph;

  assign start     = go && !busy;
  assign setup_end = busy && (cnt == CW'(SETUP - 1));
  assign decide    = busy && (cnt >= CW'(SETUP)) && (ph == PW'(SLOT - 1));
  assign last      = busy && (cnt == CW'(TOTAL - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
      ph   <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= '0;
      ph   <= '0;
    end else if (busy) begin
      if (abort || last) begin
        busy <= 1'b0;
        cnt  <= '0;
        ph   <= '0;
      end else begin
        cnt <= cnt + 1'b1;
        if (cnt < CW'(SETUP) || ph == PW'(SLOT - 1)) ph <= '0;
        else                                         ph <= ph + 1'b1;
      end
    end
  end

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt < CW'(TOTAL)));

  // R7
  no_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && go && !abort && !last) |=> (busy && cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq #(
  parameter int NBITS  = 10,
  parameter int ADDR_W = 4,
  parameter int SETUP  = 4,
  parameter int SLOT   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_req,
  input  logic [ADDR_W-1:0] chan_addr,
  input  logic              abort_req,
  input  logic              cmp_hi,
  output logic [NBITS-1:0]  dac_code,
  output logic [3:0]        smp_sel,
  output logic              busy,
  output logic [NBITS-1:0]  result,
  output logic              done,
  output logic              aborted,
  output logic              done_tgl
);
  localparam logic [NBITS-1:0] MSB = {1'b1, {(NBITS-1){1'b0}}};

  logic go, t_start, setup_end, decide, last;
  logic [3:0]       sel_dec;
  logic [NBITS-1:0] code, trial, kept;

  sar_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(start_req), .rise(go));

  sar_src_dec #(.ADDR_W(ADDR_W)) u_dec (.addr(chan_addr), .sel(sel_dec));

  sar_timer #(.SETUP(SETUP), .SLOT(SLOT), .NBITS(NBITS)) u_timer (
    .clk(clk), .rst(rst), .go(go), .abort(abort_req), .busy(busy),
    .start(t_start), .setup_end(setup_end), .decide(decide), .last(last));

  assign kept     = (code & ~trial) | (cmp_hi ? trial : '0);
  assign dac_code = code;

  always_ff @(posedge clk) begin
    if (rst) begin
      code     <= '0;
      trial    <= '0;
      result   <= '0;
      smp_sel  <= '0;
      done     <= 1'b0;
      aborted  <= 1'b0;
      done_tgl <= 1'b0;
    end else begin
      done    <= 1'b0;
      aborted <= 1'b0;
      if (t_start) begin
        code    <= '0;
        trial   <= '0;
        smp_sel <= sel_dec;
      end else if (busy && abort_req) begin
        code    <= '0;
        trial   <= '0;
        smp_sel <= '0;
        aborted <= 1'b1;
      end else begin
        if (setup_end) begin
          smp_sel <= '0;
          code    <= MSB;
          trial   <= MSB;
        end
        if (decide) begin
          code  <= kept | (trial >> 1);
          trial <= trial >> 1;
        end
        if (last) begin
          result   <= kept;
          code     <= '0;
          done     <= 1'b1;
          done_tgl <= ~done_tgl;
        end
      end
    end
  end

  // R5
  sel_onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(smp_sel));

  // R5
  sel_busy_chk: assert property (@(posedge clk) disable iff (rst) (smp_sel != '0) |-> busy);

  // R2
  done_end_chk: assert property (@(posedge clk) disable iff (rst) done |-> (!busy && $past(busy)));

  // R6
  abort_keep_chk: assert property (@(posedge clk) disable iff (rst)
    aborted |-> ($stable(result) && !done && !busy));

  // R9
  trial_onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(trial));
endmodule

// File: tb/sar_conv_seq_tb.sv
module sar_conv_seq_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_req = 1'b0;
  logic [3:0] chan_addr = '0;
  logic       abort_req = 1'b0;
  logic       cmp_hi;
  logic [9:0] dac_code, result;
  logic [3:0] smp_sel;
  logic       busy, done, aborted, done_tgl;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  int vin_ext = 0;
  int held = 0;

  always #5 clk = ~clk;

  sar_conv_seq u_dut (
    .clk(clk), .rst(rst), .start_req(start_req), .chan_addr(chan_addr),
    .abort_req(abort_req), .cmp_hi(cmp_hi), .dac_code(dac_code), .smp_sel(smp_sel),
    .busy(busy), .result(result), .done(done), .aborted(aborted), .done_tgl(done_tgl));

  // Analog model: track/hold element and comparator
  always @(posedge clk) begin
    if (smp_sel[0])      held <= vin_ext;
    else if (smp_sel[1]) held <= 512;
    else if (smp_sel[2]) held <= 0;
    else if (smp_sel[3]) held <= 1023;
  end
  assign cmp_hi = (held >= int'(dac_code));

  function automatic int exp_held(input int a, input int v);
    if (a <= 10) return v;
    if (a == 12) return 0;
    if (a == 13) return 1023;
    return 512;
  endfunction

  function automatic int exp_sel(input int a);
    if (a <= 10) return 1;
    if (a == 12) return 4;
    if (a == 13) return 8;
    return 2;
  endfunction

  function automatic int exp_code(input int h);
    return (h > 1023) ? 1023 : h;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Raise start and wait for busy; returns at the negedge where busy count = 0
  task automatic launch(input int a, input int v);
    int n;
    chan_addr = 4'(a);
    vin_ext = v;
    start_req = 1'b0;
    repeat (4) @(negedge clk);
    start_req = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (!busy && n < 10);
    chk("R1 start latency", n, 3);
  endtask

  task automatic convert(input int a, input int v, input bit restart_mid);
    int bl, h, tg;
    tg = int'(done_tgl);
    launch(a, v);
    h = exp_held(a, v);
    bl = 0;
    while (busy && bl < 60) begin
      if (bl < 4) chk("R5 sample select", int'(smp_sel), exp_sel(a));
      if (bl == 6) chk("R5 select cleared", int'(smp_sel), 0);
      if (bl == 5) chk("R9 first trial", int'(dac_code), 512);
      if (bl == 9) chk("R9 second trial", int'(dac_code), ((h >= 512) ? 512 : 0) + 256);
      if (bl == 10) start_req = 1'b0;
      if (restart_mid && bl == 20) start_req = 1'b1;
      @(negedge clk);
      bl++;
    end
    chk("R2 busy length", bl, 44);
    chk("R2 done pulse", int'(done), 1);
    if (a <= 10) chk("R3 external result", int'(result), exp_code(h));
    else         chk("R4 self-test result", int'(result), exp_code(h));
    chk("R8 toggle on completion", int'(done_tgl), tg ^ 1);
    @(negedge clk);
    chk("R2 done one cycle", int'(done), 0);
    if (restart_mid) begin
      repeat (6) @(negedge clk);
      chk("R7 no restart", int'(busy), 0);
    end
  endtask

  task automatic abort_at(input int at_cycle);
    int bl, r, tg;
    r = int'(result);
    tg = int'(done_tgl);
    launch(3, 700);
    bl = 0;
    while (bl < at_cycle) begin @(negedge clk); bl++; end
    abort_req = 1'b1;
    @(negedge clk);
    abort_req = 1'b0;
    chk("R6 busy drops", int'(busy), 0);
    chk("R6 aborted pulse", int'(aborted), 1);
    chk("R6 no done", int'(done), 0);
    chk("R6 result kept", int'(result), r);
    chk("R8 no toggle on abort", int'(done_tgl), tg);
    @(negedge clk);
    chk("R6 aborted one cycle", int'(aborted), 0);
    start_req = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 reset busy", int'(busy), 0);
    chk("R10 reset result", int'(result), 0);
    chk("R10 reset dac", int'(dac_code), 0);
    chk("R10 reset sel", int'(smp_sel), 0);
    chk("R10 reset flags", int'({done, aborted, done_tgl}), 0);

    convert(0, 0, 1'b0);
    convert(1, 1023, 1'b0);
    convert(2, 1100, 1'b0);
    convert(10, 511, 1'b0);
    convert(5, 512, 1'b1);
    convert(11, 0, 1'b0);
    convert(12, 900, 1'b0);
    convert(13, 0, 1'b0);
    convert(14, 3, 1'b0);
    convert(15, 3, 1'b0);
    abort_at(20);
    abort_at(43);
    abort_at(0);
    for (int i = 0; i < 20; i++) begin
      int a, v;
      a = int'($urandom_range(15, 0));
      v = int'($urandom_range(1100, 0));
      convert(a, v, 1'b0);
    end
    finish_run();
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=<100000", cycles);
      finish_run();
    end
  end
endmodule